// File: doc/BRIEF.md
# Victim Line Buffer

This block is a small, fully associative store that sits beside a direct-mapped cache. It catches lines that the cache pushes out. When the main array misses, the cache asks this buffer for the line by its full line address. If the buffer holds the line, it returns the line and the memory fetch is skipped. The line then leaves the buffer, so any line is held in only one place.

The buffer holds 2, 4 or 8 lines (`NUM_LINES`). Each line is 4 or 8 words of 32 bits (`LINE_WORDS`). When every slot is in use, a new eviction replaces the entry that has been in the buffer longest. If that entry is dirty, it goes out on a write-back port.

A returned line leaves the block on a read port whose width is chosen at build time (`BEAT_MODE`). It is either one 32-bit word per cycle or the whole line in a single cycle. A synchronous invalidate-all input empties the buffer in one cycle.

Top module: `victim_buffer`

## Requirements
- R1: While reset is high, and in the first cycle after it, `resp_valid`, `rd_valid`, `rd_last` and `wb_valid` are low and the buffer holds no lines.
- R2: Every eviction not made in an invalidate cycle is stored. A later lookup of that address reports `resp_hit`=1 and delivers the stored line on the read port, until the entry is taken or displaced.
- R3: `resp_valid` is high in the cycle after each cycle with `lookup_valid` high, and only then. `resp_hit` and `resp_dirty` are valid in that same cycle.
- R4: A lookup that hits removes the entry, so a second lookup of the same address misses. `resp_dirty` carries the dirty flag that was stored with the line.
- R5: An eviction into a full buffer with no hit in the same cycle replaces the entry that was evicted into the buffer earliest. All other entries stay present.
- R6: When R5 displaces a dirty entry, `wb_valid` is high in the next cycle, with that entry's address on `wb_addr` and its line on `wb_line`. A clean displaced entry produces no write-back.
- R7: In word mode (`BEAT_MODE`=BEAT_WORD) a hit streams `LINE_WORDS` beats on consecutive cycles, starting in the cycle after the lookup. Beat k carries line bits [32k+31:32k], k ascending, and `rd_last` is high on the final beat only.
- R8: In line mode (`BEAT_MODE`=BEAT_LINE) a hit delivers the whole line as a single beat in the cycle after the lookup, with `rd_last` high.
- R9: `flush_all` invalidates every entry in one cycle. A lookup in that cycle reports a miss, and an eviction in that cycle is dropped. Neither causes a write-back.
- R10: A lookup hit and an eviction in the same cycle reuse the hit entry's slot. No other entry is displaced and no write-back occurs, even when the buffer is full.
- R11: A hit that arrives while a word-mode stream is in progress restarts the read port with beat 0 of the new line in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_all | input | 1 | Invalidate every entry this cycle |
| evict_valid | input | 1 | A line is being evicted from the cache |
| evict_addr | input | ADDR_W | Line address of the evicted line |
| evict_line | input | LINE_WORDS*32 | Data of the evicted line |
| evict_dirty | input | 1 | Evicted line is modified |
| lookup_valid | input | 1 | Search request after a cache miss |
| lookup_addr | input | ADDR_W | Line address searched |
| resp_valid | output | 1 | Lookup result present |
| resp_hit | output | 1 | Lookup found the line |
| resp_dirty | output | 1 | Returned line is modified |
| rd_valid | output | 1 | Read beat present |
| rd_data | output | 32 or LINE_WORDS*32 | Read beat data |
| rd_last | output | 1 | Final beat of the line |
| wb_valid | output | 1 | Dirty displaced line to be written back |
| wb_addr | output | ADDR_W | Address of the written-back line |
| wb_line | output | LINE_WORDS*32 | Data of the written-back line |

## Verification
Lookup responses and write-backs are registered, so they are due exactly one clock after the cycle that presented the lookup or eviction. A word stream occupies the next `LINE_WORDS` cycles after a hit, and a line-mode beat occupies the single next cycle. The bench drives inputs at the falling edge and advances its queue-based model at the rising edge. At the following falling edge it compares every output of a word-mode instance and a line-mode instance, so each result is checked in the cycle it is due and in no other.

// File: rtl/vb_pkg.sv
package vb_pkg;

    localparam int WORD_W = 32;

    typedef enum logic {
        BEAT_WORD = 1'b0,
        BEAT_LINE = 1'b1
    } beat_mode_e;

    function automatic int beat_bits(input beat_mode_e mode, input int line_w);
        return (mode == BEAT_LINE) ? line_w : WORD_W;
    endfunction

    // Index of the set bit of a one-hot (or zero) vector of up to 8 bits.
    function automatic logic [2:0] onehot_idx(input logic [7:0] v);
        logic [2:0] r;
        r = '0;
        for (int i = 0; i < 8; i++) begin
            if (v[i]) r = r | 3'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/vb_match.sv
module vb_match #(
    parameter int NUM_LINES = 4,
    parameter int ADDR_W    = 26
) (
    input  logic [NUM_LINES-1:0]             valid,
    input  logic [NUM_LINES-1:0][ADDR_W-1:0] tags,
    input  logic [ADDR_W-1:0]                addr,
    output logic [NUM_LINES-1:0]             hit_vec
);

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_cmp
        assign hit_vec[g] = valid[g] && (tags[g] == addr);
    end

endmodule

// File: rtl/vb_age.sv
module vb_age #(
    parameter int NUM_LINES = 4,
    localparam int IW = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 flush,
    input  logic                 evict,
    input  logic                 take,
    input  logic [IW-1:0]        hit_idx,
    output logic [NUM_LINES-1:0] valid,
    output logic                 full,
    output logic [IW-1:0]        slot_idx,
    output logic [IW-1:0]        oldest_idx
);

    logic [NUM_LINES-1:0] valid_q;
    logic [IW-1:0]        rank_q [NUM_LINES];
    logic [IW-1:0]        free_idx;
    logic [IW:0]          thr;

    assign valid = valid_q;
    assign full  = &valid_q;

    always_comb begin
        oldest_idx = '0;
        free_idx   = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (valid_q[i] && rank_q[i] == IW'(NUM_LINES - 1)) oldest_idx = IW'(i);
        end
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (!valid_q[i]) free_idx = IW'(i);
        end
    end

    // Slot for an incoming eviction: the hit slot, else the oldest when full, else a free one.
    assign slot_idx = take ? hit_idx : (full ? oldest_idx : free_idx);
    // Entries younger than the freed rank age by one; filling a free slot ages all.
    assign thr = (take || full) ? {1'b0, rank_q[slot_idx]} : (IW + 1)'(NUM_LINES);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            for (int i = 0; i < NUM_LINES; i++) rank_q[i] <= '0;
        end else if (flush) begin
            valid_q <= '0;
        end else if (evict) begin
            for (int i = 0; i < NUM_LINES; i++) begin
                if (IW'(i) == slot_idx) begin
                    valid_q[i] <= 1'b1;
                    rank_q[i]  <= '0;
                end else if (valid_q[i] && {1'b0, rank_q[i]} < thr) begin
                    rank_q[i] <= rank_q[i] + IW'(1);
                end
            end
        end else if (take) begin
            for (int i = 0; i < NUM_LINES; i++) begin
                if (IW'(i) == hit_idx) begin
                    valid_q[i] <= 1'b0;
                end else if (valid_q[i] && rank_q[i] > rank_q[hit_idx]) begin
                    rank_q[i] <= rank_q[i] - IW'(1);
                end
            end
        end
    end

    a_r9_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush |=> (valid_q == '0));

    a_r2_evict_stored: assert property (@(posedge clk) disable iff (rst)
        (evict && !flush) |=> valid_q[$past(slot_idx)]);

    a_r4_take_frees: assert property (@(posedge clk) disable iff (rst)
        (take && !evict && !flush) |=> !valid_q[$past(hit_idx)]);

    a_r5_full_stays_full: assert property (@(posedge clk) disable iff (rst)
        (evict && full && !flush) |=> full);

    a_r10_reuse_keeps_count: assert property (@(posedge clk) disable iff (rst)
        (take && evict && !flush) |=> ($countones(valid_q) == $past($countones(valid_q))));

endmodule

// File: rtl/vb_stream.sv
module vb_stream #(
    parameter vb_pkg::beat_mode_e BEAT_MODE = vb_pkg::BEAT_WORD,
    parameter int LINE_WORDS = 4,
    localparam int LINE_W = LINE_WORDS * vb_pkg::WORD_W,
    localparam int BEAT_W = vb_pkg::beat_bits(BEAT_MODE, LINE_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [LINE_W-1:0] line_in,
    output logic              rd_valid,
    output logic [BEAT_W-1:0] rd_data,
    output logic              rd_last
);

    if (BEAT_MODE == vb_pkg::BEAT_WORD) begin : g_word
        localparam int BW = $clog2(LINE_WORDS);
        logic [LINE_WORDS-1:0][vb_pkg::WORD_W-1:0] words_q;
        logic [BW-1:0] beat_q;
        logic          active_q;
        logic          at_last;

        assign at_last = (beat_q == BW'(LINE_WORDS - 1));

        always_ff @(posedge clk) begin
            if (rst) begin
                active_q <= 1'b0;
                beat_q   <= '0;
            end else if (load) begin
                active_q <= 1'b1;
                beat_q   <= '0;
            end else if (active_q) begin
                if (at_last) active_q <= 1'b0;
                else         beat_q   <= beat_q + BW'(1);
            end
        end

        always_ff @(posedge clk) begin
            if (load) words_q <= line_in;
        end

        assign rd_valid = active_q;
        assign rd_data  = words_q[beat_q];
        assign rd_last  = active_q && at_last;

        a_r7_beats_continue: assert property (@(posedge clk) disable iff (rst)
            (rd_valid && !rd_last) |=> rd_valid);
    end else begin : g_line
        logic [LINE_W-1:0] line_q;
        logic              active_q;

        always_ff @(posedge clk) begin
            if (rst) active_q <= 1'b0;
            else     active_q <= load;
        end

        always_ff @(posedge clk) begin
            if (load) line_q <= line_in;
        end

        assign rd_valid = active_q;
        assign rd_data  = line_q;
        assign rd_last  = active_q;

        a_r8_single_beat: assert property (@(posedge clk) disable iff (rst)
            (rd_valid && !load) |=> !rd_valid);
    end

    a_r7_last_in_beat: assert property (@(posedge clk) disable iff (rst)
        rd_last |-> rd_valid);

endmodule

// File: rtl/victim_buffer.sv
module victim_buffer #(
    parameter int NUM_LINES  = 4,
    parameter int LINE_WORDS = 4,
    parameter int ADDR_W     = 26,
    parameter vb_pkg::beat_mode_e BEAT_MODE = vb_pkg::BEAT_WORD,
    localparam int LINE_W = LINE_WORDS * vb_pkg::WORD_W,
    localparam int BEAT_W = vb_pkg::beat_bits(BEAT_MODE, LINE_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush_all,
    input  logic              evict_valid,
    input  logic [ADDR_W-1:0] evict_addr,
    input  logic [LINE_W-1:0] evict_line,
    input  logic              evict_dirty,
    input  logic              lookup_valid,
    input  logic [ADDR_W-1:0] lookup_addr,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic              resp_dirty,
    output logic              rd_valid,
    output logic [BEAT_W-1:0] rd_data,
    output logic              rd_last,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [LINE_W-1:0] wb_line
);

    localparam int IW = $clog2(NUM_LINES);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LINE_W-1:0] data;
        logic              dirty;
    } entry_t;

    entry_t                          store_q [NUM_LINES];
    logic [NUM_LINES-1:0][ADDR_W-1:0] tags;
    logic [NUM_LINES-1:0]            valid;
    logic [NUM_LINES-1:0]            hit_vec;
    logic [IW-1:0]                   hit_idx;
    logic [IW-1:0]                   slot_idx;
    logic [IW-1:0]                   oldest_idx;
    logic                            full;
    logic                            take;
    logic                            store_en;
    logic                            push_out;

    always_comb begin
        for (int i = 0; i < NUM_LINES; i++) tags[i] = store_q[i].addr;
    end

    vb_match #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_match (
        .valid   (valid),
        .tags    (tags),
        .addr    (lookup_addr),
        .hit_vec (hit_vec)
    );

    assign hit_idx  = IW'(vb_pkg::onehot_idx(8'(hit_vec)));
    assign take     = lookup_valid && !flush_all && (|hit_vec);
    assign store_en = evict_valid && !flush_all;
    assign push_out = store_en && !take && full;

    vb_age #(.NUM_LINES(NUM_LINES)) u_age (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush_all),
        .evict      (store_en),
        .take       (take),
        .hit_idx    (hit_idx),
        .valid      (valid),
        .full       (full),
        .slot_idx   (slot_idx),
        .oldest_idx (oldest_idx)
    );

    always_ff @(posedge clk) begin
        if (store_en) store_q[slot_idx] <= '{addr: evict_addr, data: evict_line, dirty: evict_dirty};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid <= 1'b0;
            resp_hit   <= 1'b0;
            resp_dirty <= 1'b0;
            wb_valid   <= 1'b0;
            wb_addr    <= '0;
            wb_line    <= '0;
        end else begin
            resp_valid <= lookup_valid;
            resp_hit   <= take;
            resp_dirty <= take && store_q[hit_idx].dirty;
            wb_valid   <= push_out && store_q[oldest_idx].dirty;
            if (push_out && store_q[oldest_idx].dirty) begin
                wb_addr <= store_q[oldest_idx].addr;
                wb_line <= store_q[oldest_idx].data;
            end
        end
    end

    vb_stream #(.BEAT_MODE(BEAT_MODE), .LINE_WORDS(LINE_WORDS)) u_stream (
        .clk      (clk),
        .rst      (rst),
        .load     (take),
        .line_in  (store_q[hit_idx].data),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .rd_last  (rd_last)
    );

    a_r2_single_match: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

    a_r3_resp_follows: assert property (@(posedge clk) disable iff (rst)
        lookup_valid |=> resp_valid);

    a_r6_wb_from_evict: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> $past(evict_valid));

    a_r9_flush_misses: assert property (@(posedge clk) disable iff (rst)
        (flush_all && lookup_valid) |=> (resp_valid && !resp_hit));

    a_r10_no_wb_on_reuse: assert property (@(posedge clk) disable iff (rst)
        (take && evict_valid) |=> !wb_valid);

endmodule

// File: tb/victim_buffer_tb.sv
module victim_buffer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N   = 4;
    localparam int WPL = 4;
    localparam int AW  = 12;
    localparam int LW  = WPL * 32;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [LW-1:0] line;
        logic          dirty;
    } ent_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic flush = 1'b0, ev_v = 1'b0, ev_dirty = 1'b0, lk_v = 1'b0;
    logic [AW-1:0] ev_addr = '0, lk_addr = '0;
    logic [LW-1:0] ev_line = '0;

    logic w_resp_valid, w_resp_hit, w_resp_dirty, w_rd_valid, w_rd_last, w_wb_valid;
    logic [31:0]   w_rd_data;
    logic [AW-1:0] w_wb_addr;
    logic [LW-1:0] w_wb_line;
    logic l_resp_valid, l_resp_hit, l_resp_dirty, l_rd_valid, l_rd_last, l_wb_valid;
    logic [LW-1:0] l_rd_data;
    logic [AW-1:0] l_wb_addr;
    logic [LW-1:0] l_wb_line;

    always #(CLK_PERIOD / 2) clk = ~clk;

    victim_buffer #(.NUM_LINES(N), .LINE_WORDS(WPL), .ADDR_W(AW),
                    .BEAT_MODE(vb_pkg::BEAT_WORD)) u_dut (
        .clk(clk), .rst(rst), .flush_all(flush),
        .evict_valid(ev_v), .evict_addr(ev_addr), .evict_line(ev_line), .evict_dirty(ev_dirty),
        .lookup_valid(lk_v), .lookup_addr(lk_addr),
        .resp_valid(w_resp_valid), .resp_hit(w_resp_hit), .resp_dirty(w_resp_dirty),
        .rd_valid(w_rd_valid), .rd_data(w_rd_data), .rd_last(w_rd_last),
        .wb_valid(w_wb_valid), .wb_addr(w_wb_addr), .wb_line(w_wb_line)
    );

    victim_buffer #(.NUM_LINES(N), .LINE_WORDS(WPL), .ADDR_W(AW),
                    .BEAT_MODE(vb_pkg::BEAT_LINE)) u_dut_line (
        .clk(clk), .rst(rst), .flush_all(flush),
        .evict_valid(ev_v), .evict_addr(ev_addr), .evict_line(ev_line), .evict_dirty(ev_dirty),
        .lookup_valid(lk_v), .lookup_addr(lk_addr),
        .resp_valid(l_resp_valid), .resp_hit(l_resp_hit), .resp_dirty(l_resp_dirty),
        .rd_valid(l_rd_valid), .rd_data(l_rd_data), .rd_last(l_rd_last),
        .wb_valid(l_wb_valid), .wb_addr(l_wb_addr), .wb_line(l_wb_line)
    );

    // Behavioural model: queue ordered oldest first.
    ent_t q[$];
    logic          e_resp_valid = 0, e_resp_hit = 0, e_resp_dirty = 0, e_wb_valid = 0;
    logic [AW-1:0] e_wb_addr = '0;
    logic [LW-1:0] e_wb_line = '0;
    logic [LW-1:0] s_line = '0, l_line = '0;
    int            s_beat = 0;
    logic          s_active = 0, l_active = 0;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 0;
    string cur_req = "R1";

    function automatic logic [LW-1:0] mk_line(input logic [AW-1:0] a);
        logic [LW-1:0] r;
        for (int k = 0; k < WPL; k++) r[32*k +: 32] = {4'(k), a, 16'(a * 7 + k * 3 + 16'h5a00)};
        return r;
    endfunction

    task automatic chk(input string tag, input string what, input logic [LW-1:0] act,
                       input logic [LW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic model_step();
        logic          hit;
        logic [LW-1:0] hline;
        hit          = 0;
        hline        = '0;
        e_resp_valid = lk_v;
        e_resp_hit   = 0;
        e_resp_dirty = 0;
        e_wb_valid   = 0;
        if (flush) begin
            q.delete();
        end else begin
            if (lk_v) begin
                for (int i = 0; i < q.size(); i++) begin
                    if (!hit && q[i].addr == lk_addr) begin
                        hit          = 1;
                        hline        = q[i].line;
                        e_resp_dirty = q[i].dirty;
                        q.delete(i);
                        break;
                    end
                end
                e_resp_hit = hit;
            end
            if (ev_v) begin
                if (!hit && q.size() == N) begin
                    ent_t old;
                    old = q.pop_front();
                    if (old.dirty) begin
                        e_wb_valid = 1;
                        e_wb_addr  = old.addr;
                        e_wb_line  = old.line;
                    end
                end
                q.push_back('{addr: ev_addr, line: ev_line, dirty: ev_dirty});
            end
        end
        if (hit) begin
            s_line = hline; s_beat = 0; s_active = 1;
        end else if (s_active) begin
            if (s_beat == WPL - 1) s_active = 0;
            else                   s_beat++;
        end
        l_active = hit;
        if (hit) l_line = hline;
    endtask

    task automatic compare();
        chk("R3", "word resp_valid", w_resp_valid, e_resp_valid);
        chk("R3", "line resp_valid", l_resp_valid, e_resp_valid);
        if (e_resp_valid) begin
            chk(cur_req, "word resp_hit", w_resp_hit, e_resp_hit);
            chk(cur_req, "line resp_hit", l_resp_hit, e_resp_hit);
            chk("R4", "word resp_dirty", w_resp_dirty, e_resp_dirty);
            chk("R4", "line resp_dirty", l_resp_dirty, e_resp_dirty);
        end
        chk("R6", "word wb_valid", w_wb_valid, e_wb_valid);
        chk("R6", "line wb_valid", l_wb_valid, e_wb_valid);
        if (e_wb_valid) begin
            chk("R6", "wb_addr", w_wb_addr, e_wb_addr);
            chk("R6", "wb_line", w_wb_line, e_wb_line);
            chk("R6", "line wb_addr", l_wb_addr, e_wb_addr);
            chk("R6", "line wb_line", l_wb_line, e_wb_line);
        end
        chk("R7", "rd_valid", w_rd_valid, s_active);
        if (s_active) begin
            chk("R7", "rd_data", w_rd_data, s_line[32*s_beat +: 32]);
            chk("R7", "rd_last", w_rd_last, s_beat == WPL - 1);
        end
        chk("R8", "line rd_valid", l_rd_valid, l_active);
        if (l_active) begin
            chk("R8", "line rd_data", l_rd_data, l_line);
            chk("R8", "line rd_last", l_rd_last, 1'b1);
        end
    endtask

    task automatic cyc(input logic f, input logic ev, input logic [AW-1:0] ea, input logic ed,
                       input logic lk, input logic [AW-1:0] la);
        flush = f; ev_v = ev; ev_addr = ea; ev_line = mk_line(ea); ev_dirty = ed;
        lk_v = lk; lk_addr = la;
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, '0, 0, 0, '0);
    endtask

    task automatic evict(input logic [AW-1:0] a, input logic d);
        cyc(0, 1, a, d, 0, '0);
    endtask

    task automatic look(input logic [AW-1:0] a);
        cyc(0, 0, '0, 0, 1, a);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs low during reset
        chk("R1", "resp_valid in reset", w_resp_valid | l_resp_valid, 1'b0);
        chk("R1", "rd_valid in reset", w_rd_valid | l_rd_valid | w_rd_last | l_rd_last, 1'b0);
        chk("R1", "wb_valid in reset", w_wb_valid | l_wb_valid, 1'b0);
        rst = 1'b0;
        cur_req = "R1";
        compare();
        look(12'h0AA); // R1: empty buffer misses
        idle(1);

        cur_req = "R2";
        evict(12'h010, 0);
        evict(12'h020, 1);
        look(12'h010);
        idle(5);

        cur_req = "R4";
        look(12'h010);
        look(12'h020);
        idle(5);

        cur_req = "R5";
        evict(12'h030, 1);
        evict(12'h040, 0);
        evict(12'h050, 0);
        evict(12'h060, 1);
        evict(12'h070, 0); // displaces dirty 030: R6 write-back
        evict(12'h080, 0); // displaces clean 040: no write-back
        look(12'h030);
        look(12'h040);
        look(12'h050);
        idle(5);

        cur_req = "R10";
        evict(12'h090, 0);               // full: 060(dirty),070,080,090
        cyc(0, 1, 12'h0A0, 0, 1, 12'h070); // hit+evict, no displacement
        look(12'h060);
        idle(5);

        cur_req = "R11";
        look(12'h080);
        look(12'h090);
        idle(6);

        cur_req = "R9";
        cyc(1, 1, 12'h0B0, 1, 1, 12'h0A0);
        look(12'h0A0);
        look(12'h0B0);
        idle(2);

        cur_req = "R2";
        evict(12'h0C0, 1);
        look(12'h0C0);
        idle(5);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule